// File: doc/BRIEF.md
# Ring Lane Hop-Count Forwarder

This block handles one traffic lane of a node that sits in a ring of processing nodes. Packets arrive as streams of beats framed by valid, start-of-packet and end-of-packet flags, on one of two receive ports. Port 0 is the on-board link and port 1 is the cable link. A configuration input picks the receive port that is serviced, and a second input picks the transmit port that carries forwarded traffic.

Every packet has a hop counter in the low bits of its first word. On the head beat the block decides whether the packet has already travelled far enough. If it has, the block absorbs the whole packet. If it has not, the block forwards the packet with the counter raised by one. Removal is switched off when the configured hop limit is at least the number of nodes in the ring, because a packet that is just starting cannot then be told apart from one that has gone all the way round.

The lane's direction flag is fixed by the lane's index and is exposed as a read-only output. The path is purely combinational from the selected input to the selected output. The only state is the per-packet record of ports and decision, so the block adds no latency and passes backpressure straight through.

Top module: `ring_lane_fwd`

## Requirements
- R1: After reset, with no receive beat offered, every transmit valid is low, and the first head beat that follows is treated as a new packet.
- R2: Receive select value 0 serves port 0 (on-board) and value 1 serves port 1 (cable). The unselected receive port sees ready held low, and its offered beats are kept waiting rather than lost or forwarded.
- R3: Transmit select value 0 sends on port 0 (on-board) and value 1 sends on port 1 (cable). At most one transmit valid is high in any cycle.
- R4: On a forwarded head beat, bits [HOP_W-1:0] of the data carry the received hop count plus one. All other bits of that beat, and all following beats, leave unchanged.
- R5: When the hop limit is below the node count and the received hop count is greater than or equal to the hop limit, the whole packet is absorbed. Receive ready stays high on each of its beats and no transmit valid rises, including on its end beat.
- R6: When the hop limit is below the node count and the hop count is below the limit, the packet is forwarded.
- R7: When the hop limit is greater than or equal to the node count, no packet is removed, whatever its hop count.
- R8: A change to either select input while a packet is in flight takes effect only after that packet's end beat.
- R9: When the selected transmit port deasserts ready during a forwarded packet, the selected receive ready goes low. The output beat stays valid and unchanged, and beat order is kept.
- R10: The lane direction output is 1 for an even lane index and 0 for an odd lane index.
- R11: The removal decision taken on the head beat holds until the end beat, even if the hop limit changes mid-packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hop_limit | input | HOP_W | Hops a packet may travel before removal |
| cfg_node_count | input | HOP_W | Number of nodes in the ring |
| cfg_rx_sel | input | SEL_W | Receive port choice (0 on-board, 1 cable) |
| cfg_tx_sel | input | SEL_W | Transmit port choice (0 on-board, 1 cable) |
| lane_dir | output | 1 | Fixed direction flag from lane index |
| rx_valid | input | NUM_PORTS | Per-port receive beat valid |
| rx_sop | input | NUM_PORTS | Per-port head-of-packet flag |
| rx_eop | input | NUM_PORTS | Per-port end-of-packet flag |
| rx_data | input | NUM_PORTS x DATA_W | Per-port beat data |
| rx_ready | output | NUM_PORTS | Per-port receive ready |
| tx_valid | output | NUM_PORTS | Per-port transmit beat valid |
| tx_sop | output | NUM_PORTS | Per-port head-of-packet flag |
| tx_eop | output | NUM_PORTS | Per-port end-of-packet flag |
| tx_data | output | NUM_PORTS x DATA_W | Per-port beat data |
| tx_ready | input | NUM_PORTS | Per-port transmit ready |

## Verification
The hardest case to reach is a packet already in flight when the selects and the hop limit change. That is the only moment where the recorded state differs from the live configuration. The stimulus accepts a head beat, then flips both selects and drops the limit to zero before the next beat. It then checks that the rest of the packet still leaves on the original port and is still forwarded. The very next packet must follow the new ports and be removed.

// File: rtl/lane_fwd_pkg.sv
`timescale 1ns/1ps
package lane_fwd_pkg;

    typedef enum logic {
        PORT_BOARD = 1'b0,
        PORT_CABLE = 1'b1
    } port_e;

    typedef struct packed {
        logic busy;
        logic drop;
    } pkt_state_t;

    // Direction flag: even lanes run towards higher node indices.
    function automatic logic dir_of_lane(input int unsigned idx);
        return (idx % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    // Removal test; disabled when the limit cannot be told apart from a full lap.
    function automatic logic hop_expired(input logic [63:0] hop,
                                         input logic [63:0] limit,
                                         input logic [63:0] nodes);
        return (limit < nodes) && (hop >= limit);
    endfunction

endpackage

// File: rtl/lane_rx_mux.sv
`timescale 1ns/1ps
module lane_rx_mux #(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 64,
    localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [NUM_PORTS-1:0]             rx_valid,
    input  logic [NUM_PORTS-1:0]             rx_sop,
    input  logic [NUM_PORTS-1:0]             rx_eop,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] rx_data,
    output logic [NUM_PORTS-1:0]             rx_ready,
    input  logic [SEL_W-1:0]                 sel,
    input  logic                             sel_ready,
    output logic                             m_valid,
    output logic                             m_sop,
    output logic                             m_eop,
    output logic [DATA_W-1:0]                m_data
);
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_rdy
        assign rx_ready[i] = (sel == SEL_W'(i)) && sel_ready;
    end

    always_comb begin
        m_valid = 1'b0;
        m_sop   = 1'b0;
        m_eop   = 1'b0;
        m_data  = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (sel == SEL_W'(i)) begin
                m_valid = rx_valid[i];
                m_sop   = rx_sop[i];
                m_eop   = rx_eop[i];
                m_data  = rx_data[i];
            end
        end
    end
endmodule

// File: rtl/lane_hop_ctrl.sv
`timescale 1ns/1ps
module lane_hop_ctrl
    import lane_fwd_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 64,
    parameter int HOP_W     = 32,
    localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HOP_W-1:0]  cfg_hop_limit,
    input  logic [HOP_W-1:0]  cfg_node_count,
    input  logic [SEL_W-1:0]  cfg_rx_sel,
    input  logic [SEL_W-1:0]  cfg_tx_sel,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              o_valid,
    output logic              o_sop,
    output logic              o_eop,
    output logic [DATA_W-1:0] o_data,
    input  logic              out_ready,
    output logic [SEL_W-1:0]  act_rx,
    output logic [SEL_W-1:0]  act_tx
);
    pkt_state_t           st_q;
    logic [SEL_W-1:0]     rx_q, tx_q;
    logic                 is_head, drop_now, fire;

    assign act_rx   = st_q.busy ? rx_q : cfg_rx_sel;
    assign act_tx   = st_q.busy ? tx_q : cfg_tx_sel;
    assign is_head  = in_valid && in_sop && !st_q.busy;
    assign drop_now = st_q.busy ? st_q.drop
                    : (is_head && hop_expired(64'(in_data[HOP_W-1:0]),
                                              64'(cfg_hop_limit),
                                              64'(cfg_node_count)));
    assign in_ready = drop_now || out_ready;
    assign o_valid  = in_valid && !drop_now;
    assign o_sop    = in_sop;
    assign o_eop    = in_eop;
    assign fire     = in_valid && in_ready;

    always_comb begin
        o_data = in_data;
        if (is_head)
            o_data[HOP_W-1:0] = in_data[HOP_W-1:0] + HOP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            rx_q <= '0;
            tx_q <= '0;
        end else if (fire) begin
            if (!st_q.busy && in_sop && !in_eop) begin
                st_q.busy <= 1'b1;
                st_q.drop <= drop_now;
                rx_q      <= cfg_rx_sel;
                tx_q      <= cfg_tx_sel;
            end else if (st_q.busy && in_eop) begin
                st_q <= '0;
            end
        end
    end
endmodule

// File: rtl/lane_tx_demux.sv
`timescale 1ns/1ps
module lane_tx_demux #(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 64,
    localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [SEL_W-1:0]                 sel,
    input  logic                             o_valid,
    input  logic                             o_sop,
    input  logic                             o_eop,
    input  logic [DATA_W-1:0]                o_data,
    output logic                             out_ready,
    output logic [NUM_PORTS-1:0]             tx_valid,
    output logic [NUM_PORTS-1:0]             tx_sop,
    output logic [NUM_PORTS-1:0]             tx_eop,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] tx_data,
    input  logic [NUM_PORTS-1:0]             tx_ready
);
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_out
        assign tx_valid[i] = (sel == SEL_W'(i)) && o_valid;
        assign tx_sop[i]   = o_sop;
        assign tx_eop[i]   = o_eop;
        assign tx_data[i]  = o_data;
    end

    always_comb begin
        out_ready = 1'b0;
        for (int i = 0; i < NUM_PORTS; i++)
            if (sel == SEL_W'(i)) out_ready = tx_ready[i];
    end
endmodule

// File: rtl/ring_lane_fwd.sv
`timescale 1ns/1ps
module ring_lane_fwd
    import lane_fwd_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 64,
    parameter int HOP_W     = 32,
    parameter int LANE_IDX  = 0,
    localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [HOP_W-1:0]                 cfg_hop_limit,
    input  logic [HOP_W-1:0]                 cfg_node_count,
    input  logic [SEL_W-1:0]                 cfg_rx_sel,
    input  logic [SEL_W-1:0]                 cfg_tx_sel,
    output logic                             lane_dir,
    input  logic [NUM_PORTS-1:0]             rx_valid,
    input  logic [NUM_PORTS-1:0]             rx_sop,
    input  logic [NUM_PORTS-1:0]             rx_eop,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] rx_data,
    output logic [NUM_PORTS-1:0]             rx_ready,
    output logic [NUM_PORTS-1:0]             tx_valid,
    output logic [NUM_PORTS-1:0]             tx_sop,
    output logic [NUM_PORTS-1:0]             tx_eop,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] tx_data,
    input  logic [NUM_PORTS-1:0]             tx_ready
);
    logic              m_valid, m_sop, m_eop, in_ready;
    logic [DATA_W-1:0] m_data;
    logic              o_valid, o_sop, o_eop, out_ready;
    logic [DATA_W-1:0] o_data;
    logic [SEL_W-1:0]  act_rx, act_tx;

    assign lane_dir = dir_of_lane(LANE_IDX);

    lane_rx_mux #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_rx (
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
        .rx_ready(rx_ready), .sel(act_rx), .sel_ready(in_ready),
        .m_valid(m_valid), .m_sop(m_sop), .m_eop(m_eop), .m_data(m_data)
    );

    lane_hop_ctrl #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .HOP_W(HOP_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .cfg_hop_limit(cfg_hop_limit), .cfg_node_count(cfg_node_count),
        .cfg_rx_sel(cfg_rx_sel), .cfg_tx_sel(cfg_tx_sel),
        .in_valid(m_valid), .in_sop(m_sop), .in_eop(m_eop), .in_data(m_data),
        .in_ready(in_ready),
        .o_valid(o_valid), .o_sop(o_sop), .o_eop(o_eop), .o_data(o_data),
        .out_ready(out_ready), .act_rx(act_rx), .act_tx(act_tx)
    );

    lane_tx_demux #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_tx (
        .sel(act_tx), .o_valid(o_valid), .o_sop(o_sop), .o_eop(o_eop), .o_data(o_data),
        .out_ready(out_ready),
        .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data),
        .tx_ready(tx_ready)
    );
endmodule

// File: rtl/ring_lane_fwd_chk.sv
`timescale 1ns/1ps
module ring_lane_fwd_chk #(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 64,
    parameter int HOP_W     = 32,
    localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input logic                             clk,
    input logic                             rst,
    input logic [HOP_W-1:0]                 cfg_hop_limit,
    input logic [HOP_W-1:0]                 cfg_node_count,
    input logic [NUM_PORTS-1:0]             rx_valid,
    input logic [NUM_PORTS-1:0]             rx_sop,
    input logic [NUM_PORTS-1:0]             rx_eop,
    input logic [NUM_PORTS-1:0][DATA_W-1:0] rx_data,
    input logic [NUM_PORTS-1:0]             rx_ready,
    input logic [NUM_PORTS-1:0]             tx_valid,
    input logic [NUM_PORTS-1:0][DATA_W-1:0] tx_data,
    input logic [NUM_PORTS-1:0]             tx_ready
);
    logic             acc, a_sop, a_eop, c_busy;
    logic [HOP_W-1:0] a_hop, t_hop;

    always_comb begin
        acc = 1'b0; a_sop = 1'b0; a_eop = 1'b0; a_hop = '0; t_hop = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (rx_valid[i] && rx_ready[i]) begin
                acc   = 1'b1;
                a_sop = rx_sop[i];
                a_eop = rx_eop[i];
                a_hop = rx_data[i][HOP_W-1:0];
            end
            if (tx_valid[i]) t_hop = tx_data[i][HOP_W-1:0];
        end
    end

    // Independent view of packet framing, built from the port handshakes only.
    always_ff @(posedge clk) begin
        if (rst)                             c_busy <= 1'b0;
        else if (acc && !c_busy && a_sop && !a_eop) c_busy <= 1'b1;
        else if (acc && c_busy && a_eop)     c_busy <= 1'b0;
    end

    assert_one_tx_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_valid));

    assert_one_rx_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rx_ready));

    assert_remove_R5: assert property (@(posedge clk) disable iff (rst)
        (acc && a_sop && !c_busy && cfg_hop_limit < cfg_node_count
         && a_hop >= cfg_hop_limit) |-> (tx_valid == '0));

    assert_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && a_sop && !c_busy && cfg_hop_limit >= cfg_node_count)
        |-> (tx_valid != '0));

    assert_hop_inc_R4: assert property (@(posedge clk) disable iff (rst)
        (acc && a_sop && !c_busy && tx_valid != '0) |-> (t_hop == HOP_W'(a_hop + 1'b1)));

    assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid != '0 && (tx_valid & tx_ready) == '0) |-> (rx_ready == '0));
endmodule

bind ring_lane_fwd ring_lane_fwd_chk #(
    .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .HOP_W(HOP_W)
) u_chk (
    .clk(clk), .rst(rst), .cfg_hop_limit(cfg_hop_limit), .cfg_node_count(cfg_node_count),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
);

// File: tb/sim_ring_lane_fwd.sv
`timescale 1ns/1ps
module sim_ring_lane_fwd;
    localparam int NP = 2;
    localparam int DW = 64;
    localparam int HW = 32;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [HW-1:0]        cfg_hop_limit = '0, cfg_node_count = '0;
    logic                 cfg_rx_sel = 1'b0, cfg_tx_sel = 1'b0;
    logic                 lane_dir, lane_dir_b;
    logic [NP-1:0]        rx_valid = '0, rx_sop = '0, rx_eop = '0;
    logic [NP-1:0][DW-1:0] rx_data = '0;
    logic [NP-1:0]        rx_ready, tx_valid, tx_sop, tx_eop;
    logic [NP-1:0][DW-1:0] tx_data;
    logic [NP-1:0]        tx_ready = '1;
    logic [NP-1:0]        rx_ready_b, tx_valid_b, tx_sop_b, tx_eop_b;
    logic [NP-1:0][DW-1:0] tx_data_b;

    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    ring_lane_fwd #(.NUM_PORTS(NP), .DATA_W(DW), .HOP_W(HW), .LANE_IDX(2)) u0 (
        .clk(clk), .rst(rst), .cfg_hop_limit(cfg_hop_limit), .cfg_node_count(cfg_node_count),
        .cfg_rx_sel(cfg_rx_sel), .cfg_tx_sel(cfg_tx_sel), .lane_dir(lane_dir),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_data(tx_data), .tx_ready(tx_ready)
    );

    ring_lane_fwd #(.NUM_PORTS(NP), .DATA_W(DW), .HOP_W(HW), .LANE_IDX(3)) u1 (
        .clk(clk), .rst(rst), .cfg_hop_limit(cfg_hop_limit), .cfg_node_count(cfg_node_count),
        .cfg_rx_sel(cfg_rx_sel), .cfg_tx_sel(cfg_tx_sel), .lane_dir(lane_dir_b),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
        .rx_ready(rx_ready_b), .tx_valid(tx_valid_b), .tx_sop(tx_sop_b), .tx_eop(tx_eop_b),
        .tx_data(tx_data_b), .tx_ready(tx_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word_of(input int b, input logic [HW-1:0] hop);
        return {32'h5A00_0000 + 32'(b), (b == 0) ? hop : 32'h1234_0000 + 32'(b)};
    endfunction

    // Drives one packet beat by beat and checks each beat at the ports.
    task automatic send_pkt(input int prx, input int ptx, input logic [HW-1:0] hop,
                            input int len, input bit fwd, input int stall_beat,
                            input bit disturb, input string tag);
        for (int b = 0; b < len; b++) begin
            logic [DW-1:0] d, e;
            @(negedge clk);
            if (b == 1 && disturb) begin
                cfg_rx_sel    = ~cfg_rx_sel;
                cfg_tx_sel    = ~cfg_tx_sel;
                cfg_hop_limit = '0;
            end
            d = word_of(b, hop);
            e = d;
            if (b == 0) e[HW-1:0] = hop + 1;
            rx_valid = '0; rx_sop = '0; rx_eop = '0;
            rx_valid[prx] = 1'b1;
            rx_sop[prx]   = (b == 0);
            rx_eop[prx]   = (b == len - 1);
            rx_data[prx]  = d;
            if (b == stall_beat) begin
                tx_ready = '0;
                #1;
                chk(rx_ready[prx] == 1'b0, {tag, " R9 stall ready"}, 64'(rx_ready), 0);
                chk(tx_valid[ptx] == 1'b1, {tag, " R9 stall valid"}, 64'(tx_valid), 64'(1 << ptx));
                @(negedge clk);
                #1;
                chk(tx_data[ptx] == e, {tag, " R9 held data"}, tx_data[ptx], e);
                tx_ready = '1;
            end
            #1;
            if (fwd) begin
                chk(tx_valid == NP'(1 << ptx), {tag, " tx valid"}, 64'(tx_valid), 64'(1 << ptx));
                chk(tx_data[ptx] == e, {tag, " data"}, tx_data[ptx], e);
                chk(tx_sop[ptx] == (b == 0) && tx_eop[ptx] == (b == len - 1),
                    {tag, " framing"}, {tx_sop[ptx], tx_eop[ptx]}, {b == 0, b == len - 1});
                chk(rx_ready == NP'(1 << prx), {tag, " rx ready"}, 64'(rx_ready), 64'(1 << prx));
            end else begin
                chk(tx_valid == '0, {tag, " R5 no output"}, 64'(tx_valid), 0);
                chk(rx_ready[prx] == 1'b1, {tag, " R5 absorb"}, 64'(rx_ready), 64'(1 << prx));
            end
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = '0; rx_sop = '0; rx_eop = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(tx_valid == '0, "R1 idle tx_valid", 64'(tx_valid), 0);
        chk(lane_dir == 1'b1, "R10 even lane", 64'(lane_dir), 1);
        chk(lane_dir_b == 1'b0, "R10 odd lane", 64'(lane_dir_b), 0);
    endtask

    task automatic t_board();
        cfg_rx_sel = 0; cfg_tx_sel = 0; cfg_hop_limit = 5; cfg_node_count = 8;
        send_pkt(0, 0, 32'd2, 3, 1'b1, -1, 1'b0, "R1 R4 R6 board");
    endtask

    task automatic t_cable();
        cfg_rx_sel = 1; cfg_tx_sel = 1;
        send_pkt(1, 1, 32'd0, 2, 1'b1, -1, 1'b0, "R2 R3 cable");
        cfg_rx_sel = 1; cfg_tx_sel = 0;
        send_pkt(1, 0, 32'd3, 1, 1'b1, -1, 1'b0, "R2 R3 cross");
    endtask

    task automatic t_unselected();
        logic [DW-1:0] e;
        cfg_rx_sel = 1; cfg_tx_sel = 0;
        @(negedge clk);
        rx_valid[0] = 1'b1; rx_sop[0] = 1'b1; rx_eop[0] = 1'b1;
        rx_data[0]  = word_of(0, 32'd1);
        for (int k = 0; k < 2; k++) begin
            #1;
            chk(rx_ready[0] == 1'b0, "R2 unselected ready", 64'(rx_ready), 0);
            chk(tx_valid == '0, "R2 unselected no output", 64'(tx_valid), 0);
            @(negedge clk);
        end
        cfg_rx_sel = 0;
        e = word_of(0, 32'd2);
        #1;
        chk(tx_valid == 2'b01 && tx_data[0] == e, "R2 held beat kept", tx_data[0], e);
        @(posedge clk);
        @(negedge clk);
        rx_valid = '0; rx_sop = '0; rx_eop = '0;
    endtask

    task automatic t_remove();
        cfg_rx_sel = 0; cfg_tx_sel = 0; cfg_hop_limit = 5; cfg_node_count = 8;
        send_pkt(0, 0, 32'd5, 3, 1'b0, -1, 1'b0, "R5 at limit");
        send_pkt(0, 0, 32'd9, 1, 1'b0, -1, 1'b0, "R5 single beat");
        send_pkt(0, 0, 32'd4, 2, 1'b1, -1, 1'b0, "R6 below limit");
    endtask

    task automatic t_unlimited();
        cfg_hop_limit = 8; cfg_node_count = 8;
        send_pkt(0, 0, 32'd200, 2, 1'b1, -1, 1'b0, "R7 limit equals nodes");
        cfg_hop_limit = 0; cfg_node_count = 0;
        send_pkt(0, 0, 32'd0, 1, 1'b1, -1, 1'b0, "R7 zero nodes");
    endtask

    task automatic t_switch();
        cfg_rx_sel = 0; cfg_tx_sel = 0; cfg_hop_limit = 5; cfg_node_count = 8;
        send_pkt(0, 0, 32'd1, 4, 1'b1, -1, 1'b1, "R8 R11 mid-packet change");
        send_pkt(1, 1, 32'd0, 2, 1'b0, -1, 1'b0, "R8 R11 after boundary");
        cfg_hop_limit = 5;
    endtask

    task automatic t_stall();
        cfg_rx_sel = 0; cfg_tx_sel = 1;
        send_pkt(0, 1, 32'd3, 3, 1'b1, 1, 1'b0, "R9 backpressure");
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_board();
        t_cable();
        t_unselected();
        t_remove();
        t_unlimited();
        t_switch();
        t_stall();
        repeat (2) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule